// File: doc/BRIEF.md
# Upset-Tolerant One-Hot Sequencing Controller

This block sequences a four-step operation: waiting, armed, running and finished. It keeps its current step in a one-hot state register, with one flip-flop per step. A single event upset can flip a state bit and leave the register holding zero or two set bits. The controller checks for that every cycle. On any such word it returns to the waiting step on the next clock edge and raises a one-cycle error pulse, so it never hangs in an unreachable code.

The three request pins may change at any time relative to the clock. Each one passes through its own two-stage synchronizer before the transition logic sees it. The step outputs are decoded straight from the state register. They are all held low while the register holds an illegal word. The control pins are plain levels with no handshake, because no data flows through the block.

Top module: `upset_fsm`

## Requirements
- R1: While the synchronous reset `rst_i` is high at a clock edge, the next cycle shows the waiting step: `idle_o`=1, `armed_o`=`running_o`=`done_o`=0 and `err_o`=0.
- R2: In the waiting step (state bit 0 set), a synchronized high on `req_arm_i` moves the machine to the armed step (bit 1). Otherwise it stays waiting.
- R3: In the armed step, a synchronized high on `req_start_i` moves it to the running step (bit 2). Otherwise it stays armed. The arm and stop requests have no effect in this step.
- R4: In the running step, a synchronized high on `req_stop_i` moves it to the finished step (bit 3). Otherwise it keeps running.
- R5: The finished step lasts exactly one cycle and is always followed by the waiting step, whatever the requests are.
- R6: A state word whose count of set bits is not one, including all zeros, drives all four step outputs low during that cycle and is replaced by the waiting step at the next clock edge.
- R7: `err_o` is high for exactly the one cycle that follows a cycle holding an illegal state word, and is low after any legal word.
- R8: A request change on a pin affects the state no earlier than the third rising clock edge after it. Two edges pass through the synchronizer, and the third loads the state register.
- R9: For a legal state word, the outputs {`done_o`,`running_o`,`armed_o`,`idle_o`} equal the state bits 3..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| req_arm_i | input | 1 | Asynchronous request: leave waiting for armed |
| req_start_i | input | 1 | Asynchronous request: leave armed for running |
| req_stop_i | input | 1 | Asynchronous request: leave running for finished |
| idle_o | output | 1 | Waiting step active |
| armed_o | output | 1 | Armed step active |
| running_o | output | 1 | Running step active |
| done_o | output | 1 | Finished step active, one cycle |
| err_o | output | 1 | One-cycle pulse after an illegal state word was replaced |

## Verification
The assertions watch, on every cycle, the behaviour tied to the state word alone. They check that an illegal word returns to waiting with an error pulse, that step outputs stay quiet for an illegal word, that finished always falls through to waiting, that reset yields waiting, and that the error flag never lasts two cycles. Only the bench's scenarios can show the request-driven transitions and the three-edge synchronizer latency. The bench sweeps all sixteen possible state words by upsetting the register directly. It also sweeps every request combination against each legal step.

// File: rtl/upset_fsm_pkg.sv
package upset_fsm_pkg;
  localparam int ST_W = 4;

  localparam int IX_IDLE = 0;
  localparam int IX_ARM  = 1;
  localparam int IX_RUN  = 2;
  localparam int IX_DONE = 3;

  typedef logic [ST_W-1:0] st_t;

  localparam st_t CODE_IDLE = st_t'(1) << IX_IDLE;
  localparam st_t CODE_ARM  = st_t'(1) << IX_ARM;
  localparam st_t CODE_RUN  = st_t'(1) << IX_RUN;
  localparam st_t CODE_DONE = st_t'(1) << IX_DONE;

  localparam int REQ_N  = 3;
  localparam int RQ_ARM   = 0;
  localparam int RQ_START = 1;
  localparam int RQ_STOP  = 2;
endpackage

// File: rtl/req_sync.sv
module req_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst_i) chain[s] <= '0;
        else       chain[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst_i) chain[s] <= '0;
        else       chain[s] <= chain[s-1];
      end
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/onehot_guard.sv
module onehot_guard #(
  parameter int W = 4
) (
  input  logic [W-1:0] code_i,
  output logic         legal_o
);
  localparam int CW = $clog2(W + 1);
  logic [CW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) ones = ones + CW'(code_i[i]);
  end

  assign legal_o = (ones == CW'(1));
endmodule

// File: rtl/upset_fsm.sv
module upset_fsm
  import upset_fsm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_i,
  input  logic req_arm_i,
  input  logic req_start_i,
  input  logic req_stop_i,
  output logic idle_o,
  output logic armed_o,
  output logic running_o,
  output logic done_o,
  output logic err_o
);
  logic [REQ_N-1:0] req_raw, req_s;
  st_t              state_q, state_d, state_vis;
  logic             legal;
  logic             err_q;

  assign req_raw[RQ_ARM]   = req_arm_i;
  assign req_raw[RQ_START] = req_start_i;
  assign req_raw[RQ_STOP]  = req_stop_i;

  req_sync #(.WIDTH(REQ_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_i(rst_i), .async_i(req_raw), .sync_o(req_s)
  );

  onehot_guard #(.W(ST_W)) u_guard (
    .code_i(state_q), .legal_o(legal)
  );

  // Recovery is an explicit branch ahead of the step decode, so every
  // illegal word has a defined successor instead of a don't-care.
  always_comb begin
    state_d = CODE_IDLE;
    if (legal) begin
      unique case (1'b1)
        state_q[IX_IDLE]: state_d = req_s[RQ_ARM]   ? CODE_ARM  : CODE_IDLE;
        state_q[IX_ARM]:  state_d = req_s[RQ_START] ? CODE_RUN  : CODE_ARM;
        state_q[IX_RUN]:  state_d = req_s[RQ_STOP]  ? CODE_DONE : CODE_RUN;
        state_q[IX_DONE]: state_d = CODE_IDLE;
        default:          state_d = CODE_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst_i) begin
      state_q <= CODE_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= ~legal;
    end
  end

  assign state_vis = state_q & {ST_W{legal}};
  assign idle_o    = state_vis[IX_IDLE];
  assign armed_o   = state_vis[IX_ARM];
  assign running_o = state_vis[IX_RUN];
  assign done_o    = state_vis[IX_DONE];
  assign err_o     = err_q;
endmodule

// File: rtl/upset_fsm_chk.sv
module upset_fsm_chk
  import upset_fsm_pkg::*;
(
  input logic clk,
  input logic rst_i,
  input st_t  state_q,
  input logic idle_o,
  input logic armed_o,
  input logic running_o,
  input logic done_o,
  input logic err_o
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst_i |=> (state_q == CODE_IDLE && !err_o));

  a_r6_recover_idle: assert property (@(posedge clk) disable iff (rst_i)
    ($countones(state_q) != 1) |=> (state_q == CODE_IDLE));

  a_r6_outputs_quiet: assert property (@(posedge clk) disable iff (rst_i)
    ($countones(state_q) != 1) |-> !(idle_o | armed_o | running_o | done_o));

  a_r7_flag_raised: assert property (@(posedge clk) disable iff (rst_i)
    ($countones(state_q) != 1) |=> err_o);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst_i)
    err_o |=> !err_o);

  a_r5_done_falls_through: assert property (@(posedge clk) disable iff (rst_i)
    (state_q == CODE_DONE) |=> (state_q == CODE_IDLE));

  a_r9_outputs_onehot0: assert property (@(posedge clk) disable iff (rst_i)
    $onehot0({done_o, running_o, armed_o, idle_o}));
endmodule

bind upset_fsm upset_fsm_chk u_chk (
  .clk(clk), .rst_i(rst_i), .state_q(state_q),
  .idle_o(idle_o), .armed_o(armed_o), .running_o(running_o),
  .done_o(done_o), .err_o(err_o)
);

// File: tb/upset_fsm_test.sv
`timescale 1ns/1ps
module upset_fsm_test;
  logic clk = 1'b0;
  logic rst_i = 1'b1;
  logic req_arm_i = 1'b0, req_start_i = 1'b0, req_stop_i = 1'b0;
  logic idle_o, armed_o, running_o, done_o, err_o;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  upset_fsm uut (
    .clk(clk), .rst_i(rst_i), .req_arm_i(req_arm_i), .req_start_i(req_start_i),
    .req_stop_i(req_stop_i), .idle_o(idle_o), .armed_o(armed_o),
    .running_o(running_o), .done_o(done_o), .err_o(err_o)
  );

  function automatic logic [4:0] obs();
    return {err_o, done_o, running_o, armed_o, idle_o};
  endfunction

  task automatic chk(string tag, logic [4:0] exp);
    logic [4:0] got = obs();
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b ({err,done,run,arm,idle})", tag, got, exp);
    end
  endtask

  function automatic int pop4(logic [3:0] c);
    int n = 0;
    for (int i = 0; i < 4; i++) n += int'(c[i]);
    return n;
  endfunction

  function automatic logic [3:0] next_code(int s, logic [2:0] r);
    case (s)
      0: return r[0] ? 4'b0010 : 4'b0001;
      1: return r[1] ? 4'b0100 : 4'b0010;
      2: return r[2] ? 4'b1000 : 4'b0100;
      default: return 4'b0001;
    endcase
  endfunction

  task automatic set_req(logic [2:0] r);
    req_arm_i = r[0]; req_start_i = r[1]; req_stop_i = r[2];
  endtask

  task automatic do_reset();
    @(negedge clk);
    set_req(3'b000);
    rst_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_i = 1'b0;
  endtask

  task automatic upset(logic [3:0] c);
    force uut.state_q = c;
    #0.5;
    release uut.state_q;
  endtask

  initial begin
    #1ms;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 reset state", 5'b00001);

    // R8 latency and full walk through the sequence
    set_req(3'b001);
    @(negedge clk); chk("R8 arm not seen after one edge", 5'b00001);
    @(negedge clk); chk("R8 arm not seen after two edges", 5'b00001);
    @(negedge clk); chk("R2 armed on third edge", 5'b00010);
    set_req(3'b100);
    repeat (4) @(negedge clk); chk("R3 stop ignored while armed", 5'b00010);
    set_req(3'b010);
    repeat (2) @(negedge clk); chk("R8 start not seen after two edges", 5'b00010);
    @(negedge clk); chk("R3 running on third edge", 5'b00100);
    set_req(3'b000);
    repeat (3) @(negedge clk); chk("R4 running holds without stop", 5'b00100);
    set_req(3'b111);
    repeat (3) @(negedge clk); chk("R4 finished after stop", 5'b01000);
    @(negedge clk); chk("R5 finished lasts one cycle", 5'b00001);

    // R6/R7/R9: every possible state word injected as an upset
    do_reset();
    repeat (3) @(negedge clk);
    for (int c = 0; c < 16; c++) begin
      logic [3:0] w = 4'(c);
      logic legal = (pop4(w) == 1);
      logic [3:0] nx;
      @(negedge clk);
      upset(w);
      if (legal) chk("R9 legal word decode", {1'b0, w});
      else       chk("R6 illegal word outputs low", 5'b00000);
      if (!legal)             nx = 4'b0001;
      else if (w == 4'b1000)  nx = 4'b0001;
      else                    nx = w;
      @(negedge clk);
      if (legal) chk("R7 no flag after legal word", {1'b0, nx});
      else       chk("R6 R7 recovery with flag", {1'b1, nx});
      @(negedge clk);
      chk("R7 flag lasts one cycle", {1'b0, next_code(legal ? ((nx == 4'b0001) ? 0 : (nx == 4'b0010) ? 1 : 2) : 0, 3'b000)});
    end

    // R2-R5: every request combination against every legal step
    for (int s = 0; s < 4; s++) begin
      for (int r = 0; r < 8; r++) begin
        do_reset();
        set_req(3'(r));
        repeat (2) @(negedge clk);
        upset(4'b0001 << s);
        @(negedge clk);
        case (s)
          0: chk("R2 waiting step transition", {1'b0, next_code(s, 3'(r))});
          1: chk("R3 armed step transition", {1'b0, next_code(s, 3'(r))});
          2: chk("R4 running step transition", {1'b0, next_code(s, 3'(r))});
          default: chk("R5 finished step transition", {1'b0, next_code(s, 3'(r))});
        endcase
      end
    end

    do_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule